// File: doc/BRIEF.md
# Byte Parity Checker and Generator

This block handles parity for one 36-bit data port. It treats the word as four 9-bit bytes, and the top bit of each byte carries that byte's parity. The block watches the incoming bus and drives an active-low error flag whenever any byte breaks the parity sense set by a shared odd/even select. It forwards words to be stored with all 36 bits untouched. On reads, it can replace the stored parity bits with freshly computed ones.

Two read paths exist. A FIFO word arrives from memory and passes through a parity-regeneration stage before it enters a port output register; generate and odd/even are sampled on that clock edge. A mailbox word is presented combinationally. Its parity is regenerated only while a mailbox read with generation is requested. That regeneration borrows the same trees that check the bus, so the error flag is forced inactive for the duration. The stored mailbox contents never change.

The control inputs decode into one of five operations: `OP_NONE`, `OP_FIFO_WR`, `OP_MBOX_WR`, `OP_FIFO_RD` and `OP_MBOX_RD`. The operation is active only when the port is selected and enabled. The write/read select and the mailbox select pick among the four active operations. The output register leaves its hold condition only on `OP_FIFO_RD` and returns to it on the next cycle.

Top module: `bytepar_port`

## Requirements
- R1: Bytes occupy bits [8:0], [17:9], [26:18] and [35:27], with bits 8, 17, 26 and 35 as parity bits. `perr_n` is 0 when any byte of `bus_in` has an even count of ones while `odd_sel`=1, or an odd count while `odd_sel`=0. Otherwise `perr_n` is 1.
- R2: A corruption of two, three or four bytes at once also drives `perr_n` to 0.
- R3: While `port_cs`=1, `en`=1, `wr_nrd`=0, `mbox_sel`=1 and `gen_en`=1, `perr_n` is 1 whatever `bus_in` holds.
- R4: In the R3 condition, `rd_data` equals `mbox_q` except bits 8, 17, 26 and 35. Each of those bits carries the parity of the lower eight bits of its byte: the XOR of those bits when `odd_sel`=0, and its inverse when `odd_sel`=1.
- R5: With `mbox_sel`=1 and no mailbox read with generation, `rd_data` equals `mbox_q` on all 36 bits.
- R6: On a rising edge with `port_cs`=1, `en`=1, `wr_nrd`=0 and `mbox_sel`=0, the output register loads `fifo_q`, and `fifo_rd` is 1 during that cycle. If `gen_en`=1 at that edge, the parity bits are regenerated as in R4 using `odd_sel` at that edge; otherwise the word is loaded unchanged. With `mbox_sel`=0, `rd_data` shows the register.
- R7: The output register keeps its value on every edge without a FIFO read. This covers mailbox reads, writes, `en`=0 and `port_cs`=0.
- R8: `wr_data` equals `bus_in` on all 36 bits whatever `gen_en` is. `fifo_wr` is 1 only for a selected, enabled write with `mbox_sel`=0, and `mbox_wr` only for one with `mbox_sel`=1. At most one of `fifo_wr`, `mbox_wr` and `fifo_rd` is 1.
- R9: While `rst_n`=0 the output register is cleared to zero.
- R10: During FIFO reads and during mailbox reads without generation, bus checking stays active and `perr_n` follows R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low reset |
| port_cs | input | 1 | Port select, active high |
| en | input | 1 | Transfer enable |
| wr_nrd | input | 1 | 1 selects write, 0 selects read |
| mbox_sel | input | 1 | 1 selects the mailbox, 0 the FIFO |
| gen_en | input | 1 | Parity generation on reads |
| odd_sel | input | 1 | 1 odd parity, 0 even parity |
| bus_in | input | 36 | Incoming port data |
| fifo_q | input | 36 | Word read from FIFO memory |
| mbox_q | input | 36 | Stored mailbox word |
| perr_n | output | 1 | Parity error flag, active low |
| rd_data | output | 36 | Read data toward the port |
| wr_data | output | 36 | Word to be stored |
| fifo_wr | output | 1 | FIFO write strobe |
| mbox_wr | output | 1 | Mailbox write strobe |
| fifo_rd | output | 1 | FIFO read strobe |

## Verification
The bench sweeps random words with one, several or no corrupted bytes under both parity senses. A tree with the wrong sense or a wrong byte boundary misses or invents errors. It requests mailbox reads with generation on a bus with bad parity: a design that does not force the flag reports a false error, and one that rewrites the wrong bits corrupts data bits. For FIFO reads, generate and odd/even are changed right after the edge, which catches a design that generates parity at the output instead of at load time. Mailbox reads, writes and disabled cycles are then run to show the output register does not reload.

// File: rtl/bytepar_pkg.sv
package bytepar_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_FIFO_WR,
        OP_MBOX_WR,
        OP_FIFO_RD,
        OP_MBOX_RD
    } port_op_e;
endpackage

// File: rtl/bytepar_op_decode.sv
module bytepar_op_decode
    import bytepar_pkg::*;
(
    input  logic     port_cs,
    input  logic     en,
    input  logic     wr_nrd,
    input  logic     mbox_sel,
    output port_op_e op
);
    always_comb begin
        op = OP_NONE;
        if (port_cs && en) begin
            unique case ({wr_nrd, mbox_sel})
                2'b10:   op = OP_FIFO_WR;
                2'b11:   op = OP_MBOX_WR;
                2'b00:   op = OP_FIFO_RD;
                default: op = OP_MBOX_RD;
            endcase
        end
    end
endmodule

// File: rtl/bytepar_tree.sv
module bytepar_tree #(
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9,
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic [DATA_W-1:0] word,
    input  logic              odd_sel,
    output logic [NBYTES-1:0] fail,
    output logic [NBYTES-1:0] gen_bit
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic lo_x;
        assign lo_x       = ^word[b*BYTE_W +: BYTE_W-1];
        assign gen_bit[b] = lo_x ^ odd_sel;
        assign fail[b]    = lo_x ^ word[b*BYTE_W + BYTE_W-1] ^ odd_sel;
    end
endmodule

// File: rtl/bytepar_merge.sv
module bytepar_merge #(
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9,
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic [DATA_W-1:0] word,
    input  logic [NBYTES-1:0] gen_bit,
    input  logic              use_gen,
    output logic [DATA_W-1:0] merged
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign merged[b*BYTE_W +: BYTE_W-1] = word[b*BYTE_W +: BYTE_W-1];
        assign merged[b*BYTE_W + BYTE_W-1]  = use_gen ? gen_bit[b]
                                                      : word[b*BYTE_W + BYTE_W-1];
    end
endmodule

// File: rtl/bytepar_port.sv
module bytepar_port
    import bytepar_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9,
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_cs,
    input  logic              en,
    input  logic              wr_nrd,
    input  logic              mbox_sel,
    input  logic              gen_en,
    input  logic              odd_sel,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] fifo_q,
    input  logic [DATA_W-1:0] mbox_q,
    output logic              perr_n,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wr_data,
    output logic              fifo_wr,
    output logic              mbox_wr,
    output logic              fifo_rd
);
    function automatic logic [DATA_W-1:0] data_mask();
        logic [DATA_W-1:0] m;
        m = '1;
        for (int b = 0; b < NBYTES; b++) m[b*BYTE_W + BYTE_W-1] = 1'b0;
        return m;
    endfunction
    localparam logic [DATA_W-1:0] DMASK = data_mask();

    port_op_e          op;
    logic              mbox_gen;
    logic [DATA_W-1:0] chk_word;
    logic [NBYTES-1:0] chk_fail, chk_gen;
    logic [NBYTES-1:0] ff_fail_unused, ff_gen;
    logic [DATA_W-1:0] mbox_view, fifo_next;
    logic [DATA_W-1:0] out_q;

    bytepar_op_decode u_dec (
        .port_cs(port_cs), .en(en), .wr_nrd(wr_nrd), .mbox_sel(mbox_sel), .op(op)
    );

    assign mbox_gen = (op == OP_MBOX_RD) && gen_en;
    // Shared trees: bus checking or mailbox regeneration.
    assign chk_word = mbox_gen ? mbox_q : bus_in;

    bytepar_tree #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_chk_tree (
        .word(chk_word), .odd_sel(odd_sel), .fail(chk_fail), .gen_bit(chk_gen)
    );
    bytepar_merge #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_mbox_merge (
        .word(mbox_q), .gen_bit(chk_gen), .use_gen(mbox_gen), .merged(mbox_view)
    );

    // FIFO path: trees between memory and the output register.
    bytepar_tree #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_fifo_tree (
        .word(fifo_q), .odd_sel(odd_sel), .fail(ff_fail_unused), .gen_bit(ff_gen)
    );
    bytepar_merge #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_fifo_merge (
        .word(fifo_q), .gen_bit(ff_gen), .use_gen(gen_en), .merged(fifo_next)
    );

    // State register: output register, loads only on OP_FIFO_RD.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                out_q <= '0;
        else if (op == OP_FIFO_RD) out_q <= fifo_next;
    end

    // Output process.
    always_comb begin
        fifo_wr = 1'b0;
        mbox_wr = 1'b0;
        fifo_rd = 1'b0;
        unique case (op)
            OP_FIFO_WR: fifo_wr = 1'b1;
            OP_MBOX_WR: mbox_wr = 1'b1;
            OP_FIFO_RD: fifo_rd = 1'b1;
            default: ;
        endcase
        wr_data = bus_in;
        rd_data = mbox_sel ? mbox_view : out_q;
        perr_n  = mbox_gen ? 1'b1 : ~|chk_fail;
    end

    // R3
    mbox_gen_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_cs && en && !wr_nrd && mbox_sel && gen_en) |-> perr_n);
    // R4
    mbox_data_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_cs && en && !wr_nrd && mbox_sel) |-> ((rd_data & DMASK) == (mbox_q & DMASK)));
    // R6
    fifo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && !gen_en) |=> (out_q == $past(fifo_q)));
    // R6
    fifo_gen_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> ((out_q & DMASK) == ($past(fifo_q) & DMASK)));
    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_cs && en && !wr_nrd && !mbox_sel) |=> $stable(out_q));
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_wr, mbox_wr, fifo_rd}));
endmodule

// File: tb/bytepar_port_test.sv
module bytepar_port_test;
    localparam int W   = 36;
    localparam int OBS = 2*W + 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, port_cs, en, wr_nrd, mbox_sel, gen_en, odd_sel;
    logic [W-1:0] bus_in, fifo_q, mbox_q;
    logic perr_n, fifo_wr, mbox_wr, fifo_rd;
    logic [W-1:0] rd_data, wr_data;

    bytepar_port uut (
        .clk(clk), .rst_n(rst_n), .port_cs(port_cs), .en(en), .wr_nrd(wr_nrd),
        .mbox_sel(mbox_sel), .gen_en(gen_en), .odd_sel(odd_sel), .bus_in(bus_in),
        .fifo_q(fifo_q), .mbox_q(mbox_q), .perr_n(perr_n), .rd_data(rd_data),
        .wr_data(wr_data), .fifo_wr(fifo_wr), .mbox_wr(mbox_wr), .fifo_rd(fifo_rd)
    );

    typedef struct {
        logic [OBS-1:0] exp;
        logic [OBS-1:0] msk;
        string          tag;
    } item_t;

    item_t sbq[$];
    event  chk_ev;
    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;

    wire [OBS-1:0] obs = {perr_n, rd_data, wr_data, fifo_wr, mbox_wr, fifo_rd};

    // Monitor: pops expected items and compares against the ports.
    initial forever begin
        @(chk_ev);
        while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            total++;
            if (((obs ^ it.exp) & it.msk) != '0) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h mask=%h", it.tag, obs, it.exp, it.msk);
            end
        end
    end

    // Driver side: pushes an expectation and triggers the monitor.
    task automatic expect_obs(input logic pe, input bit cpe,
                              input logic [W-1:0] rd, input bit crd,
                              input logic [W-1:0] wr, input bit cwr,
                              input logic [2:0] st, input bit cst, input string tag);
        item_t it;
        it.exp = {pe, rd, wr, st};
        it.msk = {cpe, {W{crd}}, {W{cwr}}, {3{cst}}};
        it.tag = tag;
        sbq.push_back(it);
        #1;
        -> chk_ev;
        #1;
    endtask

    function automatic bit byte_bad(input logic [8:0] b, input bit odd);
        int n = 0;
        for (int i = 0; i < 9; i++) n += int'(b[i]);
        return ((n % 2) == 1) != odd;
    endfunction

    function automatic bit word_bad(input logic [W-1:0] w, input bit odd);
        bit r = 1'b0;
        for (int k = 0; k < 4; k++) r |= byte_bad(w[k*9 +: 9], odd);
        return r;
    endfunction

    function automatic logic [W-1:0] regen(input logic [W-1:0] w, input bit odd);
        logic [W-1:0] r = w;
        for (int k = 0; k < 4; k++) begin
            int n = 0;
            for (int i = 0; i < 8; i++) n += int'(w[k*9 + i]);
            r[k*9 + 8] = ((n % 2) == 0) ? odd : !odd;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] bad_word(input logic [W-1:0] seed, input bit odd);
        logic [W-1:0] r = regen(seed, odd);
        r[17] = ~r[17];
        return r;
    endfunction

    task automatic set_ctl(input bit cs, input bit e, input bit wn, input bit mb,
                           input bit g, input bit o);
        port_cs = cs; en = e; wr_nrd = wn; mbox_sel = mb; gen_en = g; odd_sel = o;
    endtask

    function automatic logic [W-1:0] rnd36();
        return {$urandom(), $urandom()} & {W{1'b1}};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held, f, m;
        rst_n = 1'b0;
        set_ctl(0, 0, 1, 0, 0, 0);
        bus_in = '0; fifo_q = rnd36(); mbox_q = '0;
        repeat (3) @(negedge clk);
        // R9: register cleared in reset
        expect_obs(1'b1, 0, '0, 1, '0, 0, 3'b000, 1, "R9 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: sweep of corruption patterns, both senses
        for (int i = 0; i < 60; i++) begin
            bit odd = i[0];
            int mode = i % 3;
            logic [W-1:0] w;
            @(negedge clk);
            set_ctl(0, 0, 1, 0, 0, odd);
            w = regen(rnd36(), odd);
            if (mode == 1) begin
                int k = int'($urandom % 4);
                int j = int'($urandom % 9);
                w[k*9 + j] = ~w[k*9 + j];
            end else if (mode == 2) begin
                logic [3:0] msk = (i % 4 == 0) ? 4'hF : (4'b0011 << ($urandom % 3));
                for (int k = 0; k < 4; k++)
                    if (msk[k]) w[k*9 + int'($urandom % 9)] ^= 1'b1;
            end
            bus_in = w;
            expect_obs(!word_bad(w, odd), 1, '0, 0, '0, 0, 3'b000, 0,
                       (mode == 2) ? "R2 multi-byte check" : "R1 byte check");
        end

        // R8: writes pass all bits, strobes decoded
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            set_ctl(1, 1, 1, i[0], i[1], i[0]);
            bus_in = rnd36();
            expect_obs(1'b0, 0, '0, 0, bus_in, 1, i[0] ? 3'b010 : 3'b100, 1, "R8 write path");
        end

        // R3 / R4: mailbox read with generation on a bad bus
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            set_ctl(1, 1, 0, 1, 1, i[0]);
            m = rnd36();
            mbox_q = m;
            bus_in = bad_word(rnd36(), i[0]);
            expect_obs(1'b1, 1, '0, 0, '0, 0, 3'b000, 1, "R3 flag forced");
            expect_obs(1'b0, 0, regen(m, i[0]), 1, '0, 0, 3'b000, 0, "R4 mailbox regen");
        end

        // R5 / R10: mailbox view without generation, checking active
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (i == 0) set_ctl(1, 1, 0, 1, 0, 1);
            else if (i == 1) set_ctl(1, 0, 0, 1, 1, 0);
            else set_ctl(0, 1, 0, 1, 1, 1);
            m = rnd36();
            mbox_q = m;
            bus_in = bad_word(rnd36(), odd_sel);
            expect_obs(1'b0, 1, m, 1, '0, 0, 3'b000, 0, "R5 R10 mailbox raw");
        end

        // R6: FIFO loads, parity settings sampled at the edge
        for (int i = 0; i < 4; i++) begin
            bit g = i[0];
            bit o = i[1];
            @(negedge clk);
            set_ctl(1, 1, 0, 0, g, o);
            f = rnd36();
            fifo_q = f;
            bus_in = bad_word(rnd36(), o);
            expect_obs(1'b0, 1, '0, 0, '0, 0, 3'b001, 1, "R6 R10 fifo read strobe");
            @(posedge clk);
            #1;
            set_ctl(0, 0, 1, 0, !g, !o);
            fifo_q = rnd36();
            expect_obs(1'b0, 0, g ? regen(f, o) : f, 1, '0, 0, 3'b000, 1, "R6 fifo load");
            held = g ? regen(f, o) : f;
        end

        // R7: no reload without a FIFO read
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            fifo_q = rnd36();
            if (i == 0) set_ctl(1, 1, 0, 1, 1, 0);
            else if (i == 1) set_ctl(1, 0, 0, 0, 1, 1);
            else if (i == 2) set_ctl(0, 1, 0, 0, 0, 0);
            else set_ctl(1, 1, 1, 0, 0, 1);
            @(posedge clk);
            #1;
            set_ctl(0, 0, 1, 0, 0, 0);
            expect_obs(1'b0, 0, held, 1, '0, 0, 3'b000, 0, "R7 register hold");
        end

        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule